// File: doc/BRIEF.md
# Coprocessor Command Latency Scoreboard

This block keeps track of when a geometry coprocessor will be free again after it accepts a command. Each command issue presents a 6-bit function code together with the requester's current position, which is an instruction count that only ever moves forward. The block looks up a per-function latency in a 64-entry constant table. It then records a ready point equal to the issue position plus that latency.

Any later coprocessor access is compared against the recorded ready point. An access is either a command or a register transfer: a move to or from a data or control register, a load or a store. If the access arrives before the ready point, the block reports the distance as a stall count. On the next clock edge it adds that distance to a running idle-cycle total. The busy flag and the stall count are combinational in the current position. The idle total is registered. The coprocessor's arithmetic is not part of this block.

Top module: `cop_lat_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `stall_cycles` is 0 and `idle_total` is 0.
- R2: The latency is looked up with `cmd_func`. Codes 0x00→2, 0x01→16, 0x06→8, 0x0C→6, 0x10→8, 0x11→8, 0x12→8, 0x13→19, 0x14→13, 0x16→44, 0x1B→17, 0x1C→11, 0x1E→14, 0x20→30, 0x28→5, 0x29→8, 0x2A→17, 0x2D→5, 0x2E→6, 0x30→23, 0x3D→6, 0x3E→5 and 0x3F→39. Every other code gives 1.
- R3: A cycle with `cmd_valid` high sets the ready point to `cur_pos` plus the latency of `cmd_func`. `busy` is high exactly while `cur_pos` is below the ready point.
- R4: `stall_cycles` equals the ready point minus `cur_pos` while `busy` is high, and 0 otherwise.
- R5: An access in a busy cycle adds that cycle's `stall_cycles` to `idle_total` at the next rising edge. An access is `cmd_valid` or `xfer_valid`. An access in a non-busy cycle leaves `idle_total` unchanged.
- R6: A transfer (`xfer_valid` without `cmd_valid`) never moves the ready point.
- R7: A command issued while busy is charged against the old ready point. The new ready point then counts from that command's own `cur_pos`, and the stall does not extend it.
- R8: A cycle with both `cmd_valid` and `xfer_valid` high is charged once.
- R9: `idle_total` is `IDLE_W` bits wide (32 by default) and wraps modulo 2^`IDLE_W`.
- R10: While busy with no access, `idle_total` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A coprocessor command issues this cycle |
| cmd_func | input | FUNC_W (6) | Function field of the issuing command |
| xfer_valid | input | 1 | A register transfer or load/store touches the coprocessor this cycle |
| cur_pos | input | POS_W (32) | Current instruction-count position of the requester |
| busy | output | 1 | Current position lies before the ready point |
| stall_cycles | output | POS_W (32) | Distance to the ready point, 0 when not busy |
| idle_total | output | IDLE_W (32) | Accumulated stall cycles charged to accesses |

## Verification
Two functions can fall in the same cycle: charging a stall and re-arming the ready point. Both happen when a new command issues before the previous one has finished. Directed sequences issue a command inside an earlier command's window, including one cycle that also raises a transfer. Random traffic with small position steps does the same thing often. The bench judges each such cycle with a reference model that charges against the old ready point, then re-arms from the command's own position. It checks the busy flag and stall count in the cycles that follow, and the idle total after the edge.

// File: rtl/cls_pkg.sv
// Package: shared widths and the latency function for the scoreboard.
// Assumes function codes are 6 bits; unlisted codes cost a single cycle.
package cls_pkg;
    localparam int FUNC_W = 6;
    localparam int LAT_W  = 8;

    // Latency in cycles for one function code.
    function automatic logic [LAT_W-1:0] lat_of(input logic [5:0] code);
        case (code)
            6'h00: lat_of = 8'd2;
            6'h01: lat_of = 8'd16;
            6'h06: lat_of = 8'd8;
            6'h0C: lat_of = 8'd6;
            6'h10: lat_of = 8'd8;
            6'h11: lat_of = 8'd8;
            6'h12: lat_of = 8'd8;
            6'h13: lat_of = 8'd19;
            6'h14: lat_of = 8'd13;
            6'h16: lat_of = 8'd44;
            6'h1B: lat_of = 8'd17;
            6'h1C: lat_of = 8'd11;
            6'h1E: lat_of = 8'd14;
            6'h20: lat_of = 8'd30;
            6'h28: lat_of = 8'd5;
            6'h29: lat_of = 8'd8;
            6'h2A: lat_of = 8'd17;
            6'h2D: lat_of = 8'd5;
            6'h2E: lat_of = 8'd6;
            6'h30: lat_of = 8'd23;
            6'h3D: lat_of = 8'd6;
            6'h3E: lat_of = 8'd5;
            6'h3F: lat_of = 8'd39;
            default: lat_of = 8'd1;
        endcase
    endfunction
endpackage

// File: rtl/cls_lat_rom.sv
// Module: constant latency ROM, one entry per function code.
// Assumes FUNC_W is small enough that 2**FUNC_W entries is cheap.
module cls_lat_rom #(
    parameter int FUNC_W = cls_pkg::FUNC_W,
    parameter int LAT_W  = cls_pkg::LAT_W
) (
    input  logic [FUNC_W-1:0] func,
    output logic [LAT_W-1:0]  lat
);
    localparam int DEPTH = 1 << FUNC_W;

    logic [LAT_W-1:0] rom [DEPTH];

    // Fill each ROM word from the package function.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign rom[g] = LAT_W'(cls_pkg::lat_of(6'(g)));
    end

    assign lat = rom[func];

    // R2: no code may yield a zero latency.
    always_comb begin
        a_r2_lat_nonzero: assert (lat != '0) else $error("R2 zero latency");
    end
endmodule

// File: rtl/cls_ready_track.sv
// Module: holds the ready point and derives busy and stall distance.
// Assumes cur_pos never decreases and does not wrap during use.
module cls_ready_track #(
    parameter int POS_W = 32,
    parameter int LAT_W = cls_pkg::LAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [POS_W-1:0] cur_pos,
    input  logic [LAT_W-1:0] lat,
    output logic             busy,
    output logic [POS_W-1:0] stall
);
    logic [POS_W-1:0] ready_pt;

    // Re-arm the ready point on every command issue.
    always_ff @(posedge clk) begin
        if (!rst_n)     ready_pt <= '0;
        else if (issue) ready_pt <= cur_pos + POS_W'(lat);
    end

    assign busy  = cur_pos < ready_pt;
    assign stall = busy ? (ready_pt - cur_pos) : '0;

    // R6: without a command the ready point must not move.
    a_r6_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(ready_pt));

    // R4: a free coprocessor reports no stall.
    a_r4_free_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (stall == '0));
endmodule

// File: rtl/cls_idle_accum.sv
// Module: wrapping accumulator of stall cycles charged to accesses.
// Assumes the amount is already zero when nothing is charged.
module cls_idle_accum #(
    parameter int IDLE_W = 32,
    parameter int POS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              charge,
    input  logic [POS_W-1:0]  amount,
    output logic [IDLE_W-1:0] total
);
    // Add the stall distance on a charged cycle; modulo 2**IDLE_W.
    always_ff @(posedge clk) begin
        if (!rst_n)      total <= '0;
        else if (charge) total <= total + IDLE_W'(amount);
    end

    // R10: no charge leaves the total untouched.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !charge |=> $stable(total));
endmodule

// File: rtl/cop_lat_scoreboard.sv
// Module: top of the coprocessor latency scoreboard.
// Combines the latency ROM, ready-point tracker and idle accumulator.
// Assumes cur_pos is monotone; commands and transfers share one charge.
module cop_lat_scoreboard #(
    parameter int FUNC_W = cls_pkg::FUNC_W,
    parameter int LAT_W  = cls_pkg::LAT_W,
    parameter int POS_W  = 32,
    parameter int IDLE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [FUNC_W-1:0] cmd_func,
    input  logic              xfer_valid,
    input  logic [POS_W-1:0]  cur_pos,
    output logic              busy,
    output logic [POS_W-1:0]  stall_cycles,
    output logic [IDLE_W-1:0] idle_total
);
    logic [LAT_W-1:0] lat;
    logic             access;
    logic             charge;

    assign access = cmd_valid | xfer_valid;
    assign charge = access & busy;

    cls_lat_rom #(.FUNC_W(FUNC_W), .LAT_W(LAT_W)) u_rom (
        .func (cmd_func),
        .lat  (lat)
    );

    cls_ready_track #(.POS_W(POS_W), .LAT_W(LAT_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (cmd_valid),
        .cur_pos (cur_pos),
        .lat     (lat),
        .busy    (busy),
        .stall   (stall_cycles)
    );

    cls_idle_accum #(.IDLE_W(IDLE_W), .POS_W(POS_W)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .charge (charge),
        .amount (stall_cycles),
        .total  (idle_total)
    );

    // R4: a busy coprocessor always reports a nonzero stall.
    a_r4_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (stall_cycles != '0));

    // R5: an access while free does not change the idle total.
    a_r5_free_access: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !busy) |=> $stable(idle_total));
endmodule

// File: tb/cop_lat_scoreboard_bench.sv
`timescale 1ns/1ps
module cop_lat_scoreboard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_func = '0;
    logic        xfer_valid = 1'b0;
    logic [31:0] cur_pos = '0;
    logic        busy, busy_n;
    logic [31:0] stall_cycles, stall_n;
    logic [31:0] idle_total;
    logic [7:0]  idle_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_ready = '0;
    logic [31:0] m_idle  = '0;
    logic [7:0]  m_idle_n = '0;

    always #2.5 clk = ~clk;

    cop_lat_scoreboard u_cop_lat_scoreboard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .xfer_valid(xfer_valid), .cur_pos(cur_pos), .busy(busy),
        .stall_cycles(stall_cycles), .idle_total(idle_total)
    );

    cop_lat_scoreboard #(.IDLE_W(8)) u_cop_lat_scoreboard_narrow (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .xfer_valid(xfer_valid), .cur_pos(cur_pos), .busy(busy_n),
        .stall_cycles(stall_n), .idle_total(idle_n)
    );

    // Reference latency per the requirement R2 list.
    function automatic logic [31:0] lat_ref(input logic [5:0] f);
        case (f)
            6'h00: return 2;   6'h01: return 16;  6'h06: return 8;
            6'h0C: return 6;   6'h10: return 8;   6'h11: return 8;
            6'h12: return 8;   6'h13: return 19;  6'h14: return 13;
            6'h16: return 44;  6'h1B: return 17;  6'h1C: return 11;
            6'h1E: return 14;  6'h20: return 30;  6'h28: return 5;
            6'h29: return 8;   6'h2A: return 17;  6'h2D: return 5;
            6'h2E: return 6;   6'h30: return 23;  6'h3D: return 6;
            6'h3E: return 5;   6'h3F: return 39;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One cycle: drive, check combinational outputs, update model, check idle.
    task automatic step(input bit c, input bit x, input logic [5:0] f,
                        input logic [31:0] p, input string tag);
        logic        e_busy;
        logic [31:0] e_stall;
        @(negedge clk);
        cmd_valid = c; xfer_valid = x; cmd_func = f; cur_pos = p;
        #1;
        e_busy  = p < m_ready;
        e_stall = e_busy ? m_ready - p : 32'd0;
        chk(busy == e_busy, "R3 busy", 64'(busy), 64'(e_busy));
        chk(stall_cycles == e_stall, "R4 stall", 64'(stall_cycles), 64'(e_stall));
        if ((c || x) && e_busy) begin
            m_idle   = m_idle + e_stall;
            m_idle_n = m_idle_n + e_stall[7:0];
        end
        if (c) m_ready = p + lat_ref(f);
        @(posedge clk);
        #1;
        chk(idle_total == m_idle, tag, 64'(idle_total), 64'(m_idle));
        chk(idle_n == m_idle_n, "R9 wrap", 64'(idle_n), 64'(m_idle_n));
    endtask

    initial begin
        #(200000.0 * 5.0);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        report();
    end

    initial begin
        logic [31:0] pos;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
        chk(stall_cycles == 0, "R1 stall", 64'(stall_cycles), 0);
        chk(idle_total == 0, "R1 idle", 64'(idle_total), 0);

        // R2: every table entry seen as stall one cycle later at same position
        for (int f = 0; f < 64; f++) begin
            pos = 32'd1000 + 32'(f) * 32'd300;
            step(1'b1, 1'b0, 6'(f), pos, "R5 idle");
            @(negedge clk);
            cmd_valid = 1'b0; xfer_valid = 1'b0; cur_pos = pos;
            #1;
            chk(stall_cycles == lat_ref(6'(f)), "R2 latency",
                64'(stall_cycles), 64'(lat_ref(6'(f))));
        end

        // R6: a transfer leaves the ready point alone
        step(1'b1, 1'b0, 6'h16, 32'd30000, "R5 idle");
        step(1'b0, 1'b1, 6'h3F, 32'd30010, "R5 idle");
        @(negedge clk);
        cmd_valid = 1'b0; xfer_valid = 1'b0; cur_pos = 32'd30010;
        #1;
        chk(stall_cycles == 34, "R6 ready kept", 64'(stall_cycles), 34);
        chk(idle_total == 34, "R6 charge", 64'(idle_total), 34);

        // R7: command while busy, re-armed from its own position
        step(1'b1, 1'b0, 6'h01, 32'd30100, "R5 idle");
        step(1'b1, 1'b0, 6'h13, 32'd30105, "R7 charge old");
        @(negedge clk);
        cmd_valid = 1'b0; cur_pos = 32'd30105;
        #1;
        chk(stall_cycles == 19, "R7 new ready", 64'(stall_cycles), 19);
        chk(idle_total == 45, "R7 idle", 64'(idle_total), 45);

        // R8: command and transfer together charged once
        step(1'b1, 1'b1, 6'h28, 32'd30110, "R8 single charge");
        chk(idle_total == 59, "R8 idle", 64'(idle_total), 59);

        // R10: busy with no access holds the total
        step(1'b0, 1'b0, 6'h00, 32'd30111, "R10 hold");
        chk(idle_total == 59, "R10 idle", 64'(idle_total), 59);

        // Random traffic (R3, R4, R5, R7, R8, R9 through the model)
        pos = 32'd31000;
        for (int i = 0; i < 3000; i++) begin
            pos = pos + 32'($urandom_range(0, 5));
            step(($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0),
                 6'($urandom_range(0, 63)), pos, "R5 idle");
        end
        report();
    end
endmodule